// File: doc/BRIEF.md
# Dual Repeating Loop-Code Detector

This block watches a serial receive line, one bit per line clock, for two repeating codes at once: a loop-up code and a loop-down code. Each code is programmed by a 16-bit definition and a 3-bit length select. A detector for a code first finds the phase of the code in the stream. It then counts the received bits that disagree with the code over a long integration window. If the disagreements stay within a fixed fraction of the window, it raises a sticky flag for that code.

Both detectors share one history register of the most recent sixteen received bits. Each detector runs its own two-state machine. In `S_ACQ` (acquire) it compares the history against every rotation of its code. It takes the transition *lock* to `S_TRACK` (track) on the lowest rotation that matches exactly, provided enough bits have arrived and the configuration is unchanged. In `S_TRACK` it checks every new bit against the code bit at the current phase. The transitions out of `S_TRACK` are:
- *window pass*: stays in `S_TRACK` with the phase kept and the counts restarted.
- *window fail*: goes back to `S_ACQ`.
- *reconfigure*: a change of code or length goes back to `S_ACQ` at once.

The window length `WINDOW_BITS` is a parameter counted in bits. The default of 98304 bits gives 48 ms at 2.048 Mbit/s. The error allowance is `WINDOW_BITS >> ERR_SHIFT`, which is 1/64 of the window by default. This meets a bit error rate of 1e-2 with margin. A host clears both flags with one clear input.

Top module: `loop_code_detector`

## Requirements
- R1: The length select picks the code length. A value n from 0 to 6 selects n+1 bits and 7 selects 16 bits. The active code is bits 15 down to 16-L of the definition, and bit 15 is the first bit on the line.
- R2: A detector locks only when the newest L received bits equal some rotation of its L-bit code, and only once at least L bits have arrived since reset. A stream containing no such rotation never raises its flag.
- R3: After reset release, a clean repeating code of length L raises its flag exactly after clock edge L + WINDOW_BITS + 1, counting the first edge that samples a bit as edge 1.
- R4: A window raises the flag when its mismatch count is at most WINDOW_BITS >> ERR_SHIFT. One mismatch more gives no flag at the end of that window.
- R5: A failed window returns the detector to acquisition. With a clean stream, it relocks on the next edge and the flag rises WINDOW_BITS + 1 edges after the failing edge.
- R6: The two detectors work independently, each with its own code and length. A stream that carries only one code flags only that code, and both flags rise together when both codes match.
- R7: A flag stays set after its code disappears, until a clear.
- R8: `status_clr` drops both flags on the next edge. A code that is still present sets its flag again at the end of the current window, without relocking.
- R9: When a passing window ends in the same cycle as `status_clr`, the flag is set.
- R10: Any change of a code definition or length select abandons the current window and restarts acquisition for that detector.
- R11: Reset clears both flags and places both detectors in acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one received bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial data |
| up_code | input | 16 | Loop-up code definition, left-justified |
| up_len_sel | input | 3 | Loop-up code length select |
| dn_code | input | 16 | Loop-down code definition, left-justified |
| dn_len_sel | input | 3 | Loop-down code length select |
| status_clr | input | 1 | Clears both status flags |
| loop_up_flag | output | 1 | Sticky loop-up detected flag |
| loop_down_flag | output | 1 | Sticky loop-down detected flag |

## Verification
A flag is due a known number of edges after a stimulus:
- L + WINDOW_BITS + 1 edges after reset release for a clean code.
- WINDOW_BITS + 1 edges after the edge of a failed window.
- WINDOW_BITS + 1 edges after the first edge on which a changed configuration has stayed steady.

A clear or a reset takes effect on the very next edge. The bench counts every rising edge it drives and samples the flags on the following falling edge. For each timing it checks the flag one edge before it is due and again on the edge it is due, so an early or late flag both show up. The table-driven cases sample at a fixed edge that lies past the latest first window and before any second window can end.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int LCD_CODE_W = 16;
    localparam int LCD_SEL_W  = 3;
    localparam int LCD_LEN_W  = $clog2(LCD_CODE_W + 1);
    localparam int LCD_PH_W   = $clog2(LCD_CODE_W);

    typedef enum logic [0:0] {
        S_ACQ   = 1'b0,
        S_TRACK = 1'b1
    } trk_state_e;

    // length select: 0..6 -> 1..7 bits, all ones -> full code width
    function automatic logic [LCD_LEN_W-1:0] lcd_len_decode(input logic [LCD_SEL_W-1:0] sel);
        if (sel == '1) begin
            return LCD_LEN_W'(LCD_CODE_W);
        end
        return LCD_LEN_W'(sel) + LCD_LEN_W'(1);
    endfunction

endpackage

// File: rtl/lcd_history.sv
module lcd_history
    import lcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_i,
    output logic [LCD_CODE_W-1:0] hist_o,
    output logic [LCD_LEN_W-1:0]  fill_o
);

    // bit 0 holds the most recent received bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_o <= '0;
            fill_o <= '0;
        end else begin
            hist_o <= {hist_o[LCD_CODE_W-2:0], rx_i};
            if (fill_o != LCD_LEN_W'(LCD_CODE_W)) begin
                fill_o <= fill_o + LCD_LEN_W'(1);
            end
        end
    end

    p_fill_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= LCD_LEN_W'(LCD_CODE_W));

    p_fill_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> fill_o >= $past(fill_o));

endmodule

// File: rtl/lcd_rot_match.sv
module lcd_rot_match
    import lcd_pkg::*;
(
    input  logic [LCD_CODE_W-1:0] hist_i,
    input  logic [LCD_CODE_W-1:0] code_i,
    input  logic [LCD_LEN_W-1:0]  len_i,
    output logic                  hit_o,
    output logic [LCD_PH_W-1:0]   rot_o
);

    // rotation r matches when the newest len bits equal the code
    // started at phase r; the lowest matching r wins
    always_comb begin : rot_scan
        int  n;
        int  idx;
        logic ok;
        hit_o = 1'b0;
        rot_o = '0;
        n     = int'(len_i);
        idx   = 0;
        ok    = 1'b0;
        for (int r = LCD_CODE_W - 1; r >= 0; r--) begin
            ok = (r < n);
            for (int j = 0; j < LCD_CODE_W; j++) begin
                if (r < n && j < n) begin
                    idx = j - r;
                    if (idx < 0) begin
                        idx = idx + n;
                    end
                    if (hist_i[j] != code_i[LCD_CODE_W - n + idx]) begin
                        ok = 1'b0;
                    end
                end
            end
            if (ok) begin
                hit_o = 1'b1;
                rot_o = LCD_PH_W'(r);
            end
        end
    end

endmodule

// File: rtl/lcd_tracker.sv
module lcd_tracker
    import lcd_pkg::*;
#(
    parameter int WINDOW_BITS = 98304,
    parameter int ERR_SHIFT   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LCD_CODE_W-1:0] hist_i,
    input  logic [LCD_LEN_W-1:0]  fill_i,
    input  logic [LCD_CODE_W-1:0] code_i,
    input  logic [LCD_SEL_W-1:0]  sel_i,
    input  logic                  clr_i,
    output logic                  flag_o
);

    localparam int CNT_W = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1;
    localparam int ERR_W = CNT_W + 1;
    localparam int CFG_W = LCD_CODE_W + LCD_SEL_W;
    localparam int LIMIT = WINDOW_BITS >> ERR_SHIFT;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WINDOW_BITS - 1);
    localparam logic [ERR_W-1:0] ERR_MAX  = ERR_W'(LIMIT);

    trk_state_e           state_q, state_d;
    logic [LCD_LEN_W-1:0] len;
    logic [CFG_W-1:0]     cfg_q;
    logic                 cfg_chg;
    logic                 hit;
    logic [LCD_PH_W-1:0]  rot;
    logic [LCD_PH_W-1:0]  ph_q, ph_nxt;
    logic [CNT_W-1:0]     bit_q;
    logic [ERR_W-1:0]     err_q, err_sum;
    logic                 exp_bit, mism;
    logic                 acq_go, win_end, win_pass;

    assign len     = lcd_len_decode(sel_i);
    assign cfg_chg = ({code_i, sel_i} != cfg_q);

    lcd_rot_match u_match (
        .hist_i (hist_i),
        .code_i (code_i),
        .len_i  (len),
        .hit_o  (hit),
        .rot_o  (rot)
    );

    assign acq_go   = (state_q == S_ACQ) && !cfg_chg && hit && (fill_i >= len);
    assign exp_bit  = code_i[LCD_CODE_W - 1 - int'(ph_q)];
    assign mism     = (state_q == S_TRACK) && (hist_i[0] != exp_bit);
    assign err_sum  = err_q + ERR_W'(mism);
    assign win_end  = (state_q == S_TRACK) && (bit_q == LAST_BIT);
    assign win_pass = win_end && !cfg_chg && (err_sum <= ERR_MAX);
    assign ph_nxt   = ({1'b0, ph_q} == len - LCD_LEN_W'(1)) ? '0 : ph_q + LCD_PH_W'(1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ACQ: begin
                if (acq_go) begin
                    state_d = S_TRACK;          // lock
                end
            end
            S_TRACK: begin
                if (cfg_chg) begin
                    state_d = S_ACQ;            // reconfigure
                end else if (win_end && !win_pass) begin
                    state_d = S_ACQ;            // window fail
                end
            end
            default: state_d = S_ACQ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ACQ;
        end else begin
            state_q <= state_d;
        end
    end

    // phase, window counters and configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ph_q  <= '0;
            bit_q <= '0;
            err_q <= '0;
        end else begin
            cfg_q <= {code_i, sel_i};
            if (state_q == S_ACQ) begin
                ph_q  <= rot;
                bit_q <= '0;
                err_q <= '0;
            end else begin
                ph_q <= ph_nxt;
                if (win_end) begin
                    bit_q <= '0;
                    err_q <= '0;
                end else begin
                    bit_q <= bit_q + CNT_W'(1);
                    err_q <= err_sum;
                end
            end
        end
    end

    // sticky status output; a passing window outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (win_pass) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRACK && !cfg_chg) |-> ({1'b0, ph_q} < len));

    p_rise_at_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(state_q == S_TRACK && bit_q == LAST_BIT));

    p_err_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRACK) |-> (err_q <= {1'b0, bit_q}));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    p_fall_on_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_i));

    p_cfg_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (state_q == S_ACQ));

endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector
    import lcd_pkg::*;
#(
    parameter int WINDOW_BITS = 98304,
    parameter int ERR_SHIFT   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_bit,
    input  logic [15:0] up_code,
    input  logic [2:0]  up_len_sel,
    input  logic [15:0] dn_code,
    input  logic [2:0]  dn_len_sel,
    input  logic        status_clr,
    output logic        loop_up_flag,
    output logic        loop_down_flag
);

    localparam int N_CODES = 2;

    logic [LCD_CODE_W-1:0] hist;
    logic [LCD_LEN_W-1:0]  fill;
    logic [LCD_CODE_W-1:0] code_a [N_CODES];
    logic [LCD_SEL_W-1:0]  sel_a  [N_CODES];
    logic                  flag_a [N_CODES];

    assign code_a[0] = up_code;
    assign sel_a[0]  = up_len_sel;
    assign code_a[1] = dn_code;
    assign sel_a[1]  = dn_len_sel;

    lcd_history u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_bit),
        .hist_o (hist),
        .fill_o (fill)
    );

    for (genvar c = 0; c < N_CODES; c++) begin : g_code
        lcd_tracker #(
            .WINDOW_BITS (WINDOW_BITS),
            .ERR_SHIFT   (ERR_SHIFT)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .hist_i (hist),
            .fill_i (fill),
            .code_i (code_a[c]),
            .sel_i  (sel_a[c]),
            .clr_i  (status_clr),
            .flag_o (flag_a[c])
        );
    end

    assign loop_up_flag   = flag_a[0];
    assign loop_down_flag = flag_a[1];

endmodule

// File: tb/sim_loop_code_detector.sv
module sim_loop_code_detector;

    localparam int CLK_PERIOD = 10;
    localparam int W_BITS     = 64;
    localparam int E_SHIFT    = 4;
    localparam int SAMPLE_AT  = W_BITS + 20;

    typedef struct packed {
        logic [15:0] uc;
        logic [2:0]  us;
        logic [15:0] dc;
        logic [2:0]  ds;
        logic [1:0]  src;   // 0 up code, 1 down code, 2 all ones, 3 all zeros
        logic [3:0]  nerr;
        logic        eu;
        logic        ed;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h8000, 3'b100, 16'h8000, 3'b010, 2'd0, 4'd0, 1'b1, 1'b0, 4'd6},  // up only
        '{16'h8000, 3'b100, 16'h8000, 3'b010, 2'd1, 4'd0, 1'b0, 1'b1, 4'd6},  // down only
        '{16'h8000, 3'b100, 16'h8000, 3'b010, 2'd0, 4'd4, 1'b1, 1'b0, 4'd4},  // at limit
        '{16'h8000, 3'b100, 16'h8000, 3'b010, 2'd0, 4'd5, 1'b0, 1'b0, 4'd4},  // one over
        '{16'hF0A5, 3'b111, 16'h8000, 3'b010, 2'd0, 4'd0, 1'b1, 1'b0, 4'd1},  // 16 bits
        '{16'h8000, 3'b000, 16'h8000, 3'b010, 2'd2, 4'd0, 1'b1, 1'b0, 4'd1},  // 1 bit
        '{16'hA000, 3'b110, 16'h8000, 3'b010, 2'd0, 4'd0, 1'b1, 1'b0, 4'd1},  // 7 bits
        '{16'h8000, 3'b100, 16'h8000, 3'b100, 2'd0, 4'd0, 1'b1, 1'b1, 4'd6},  // both
        '{16'h8000, 3'b100, 16'hE000, 3'b011, 2'd1, 4'd4, 1'b0, 1'b1, 4'd4},  // down at limit
        '{16'h8000, 3'b100, 16'h8000, 3'b010, 2'd3, 4'd0, 1'b0, 1'b0, 4'd2}   // no rotation
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b0;
    logic [15:0] up_code = 16'h8000;
    logic [2:0]  up_sel = 3'b100;
    logic [15:0] dn_code = 16'h8000;
    logic [2:0]  dn_sel = 3'b010;
    logic        clr = 1'b0;
    logic        up_flag, dn_flag;

    logic [15:0] s_code = 16'h8000;
    int          s_len = 5;
    int          s_src = 0;
    int          s_nerr = 0;
    int          edge_n = 0;
    int          checks = 0;
    int          failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    loop_code_detector #(
        .WINDOW_BITS (W_BITS),
        .ERR_SHIFT   (E_SHIFT)
    ) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_bit         (rx),
        .up_code        (up_code),
        .up_len_sel     (up_sel),
        .dn_code        (dn_code),
        .dn_len_sel     (dn_sel),
        .status_clr     (clr),
        .loop_up_flag   (up_flag),
        .loop_down_flag (dn_flag)
    );

    function automatic int lenof(input logic [2:0] sel);
        return (sel == 3'b111) ? 16 : int'(sel) + 1;
    endfunction

    function automatic string rtag(input logic [3:0] n);
        case (n)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd4:    return "R4";
            default: return "R6";
        endcase
    endfunction

    // bit k of the line stream, with evenly spaced flips inside the first window
    function automatic logic sbit(input int k);
        logic b;
        int   d;
        case (s_src)
            0, 1:    b = s_code[15 - (k % s_len)];
            2:       b = 1'b1;
            default: b = 1'b0;
        endcase
        d = k - s_len - 3;
        if (s_nerr > 0 && d >= 0 && (d % 7) == 0 && (d / 7) < s_nerr) begin
            b = ~b;
        end
        return b;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic load_vec(input vec_t v);
        up_code = v.uc;
        up_sel  = v.us;
        dn_code = v.dc;
        dn_sel  = v.ds;
        s_src   = int'(v.src);
        s_nerr  = int'(v.nerr);
        s_code  = (v.src == 2'd1) ? v.dc : v.uc;
        s_len   = (v.src == 2'd1) ? lenof(v.ds) : lenof(v.us);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clr   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        edge_n = 0;
        rx     = sbit(0);
    endtask

    // advance n rising edges; returns at the falling edge after the last one
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            edge_n++;
            @(negedge clk);
            rx = sbit(edge_n);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R11: flags low while reset is held
        @(negedge clk);
        chk(up_flag, 1'b0, "R11", "up flag in reset");
        chk(dn_flag, 1'b0, "R11", "down flag in reset");

        // table of vectors, each sampled after the first window
        for (int v = 0; v < NV; v++) begin
            load_vec(VECS[v]);
            do_reset();
            step(SAMPLE_AT);
            chk(up_flag, VECS[v].eu, rtag(VECS[v].rq), $sformatf("vector %0d up flag", v));
            chk(dn_flag, VECS[v].ed, rtag(VECS[v].rq), $sformatf("vector %0d down flag", v));
        end

        // R3: exact first-flag edge, L=5, W=64 -> edge 70
        load_vec(VECS[0]);
        do_reset();
        step(69);
        chk(up_flag, 1'b0, "R3", "up flag one edge early");
        step(1);
        chk(up_flag, 1'b1, "R3", "up flag on due edge");
        chk(dn_flag, 1'b0, "R6", "down flag stays low");

        // R8: clear at edge 80, reassert at end of current window (edge 134)
        step(9);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        chk(up_flag, 1'b0, "R8", "up flag after clear");
        step(53);
        chk(up_flag, 1'b0, "R8", "up flag before next window end");
        step(1);
        chk(up_flag, 1'b1, "R8", "up flag after next window end");

        // R9: clear coinciding with the passing window end
        do_reset();
        step(69);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        chk(up_flag, 1'b1, "R9", "set outranks clear");

        // R7: flag holds after the code disappears
        s_src = 3;
        step(130);
        chk(up_flag, 1'b1, "R7", "up flag sticky without code");
        chk(dn_flag, 1'b0, "R7", "down flag untouched");

        // R11: asynchronous reset clears a set flag
        rst_n = 1'b0;
        @(negedge clk);
        chk(up_flag, 1'b0, "R11", "up flag cleared by reset");

        // R5: failed window at edge 70, relock at 71, flag at 135
        load_vec(VECS[3]);
        do_reset();
        step(70);
        chk(up_flag, 1'b0, "R5", "no flag after failed window");
        step(64);
        chk(up_flag, 1'b0, "R5", "no flag one edge before relock window end");
        step(1);
        chk(up_flag, 1'b1, "R5", "flag after relocked window");

        // R10: length pulse seen at edges 31..32, relock at 33, flag at 97
        load_vec(VECS[0]);
        do_reset();
        step(30);
        up_sel = 3'b000;
        step(1);
        up_sel = 3'b100;
        step(39);
        chk(up_flag, 1'b0, "R10", "window abandoned after reconfigure");
        step(26);
        chk(up_flag, 1'b0, "R10", "no flag one edge before restarted window end");
        step(1);
        chk(up_flag, 1'b1, "R10", "flag after restarted window");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule